// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the slave side of a 256-word by 16-bit serial EEPROM on a four-wire bus: chip select, serial clock, serial data in and serial data out. It works in the system clock domain and samples the bus lines on every system clock edge. Each instruction is a start bit of 1, a 2-bit opcode and an 8-bit address sent MSB first. Depending on the opcode, 16 data bits follow. The engine decodes the instruction, streams read data, keeps a write-enable latch and runs a self-timed programming cycle on its own internal word array.

Reads can run for as long as select stays high. The address steps forward after every word, and there is no gap bit between words. A write, erase or bulk operation is armed once its last bit has been taken. Programming starts only if select is dropped before another serial clock rise arrives. The programming time is a count of system clock cycles. While it runs, raising select shows a low level on data out and the bus is not listened to. After it ends, raising select shows a high level.

Top module: `uwire_eeprom_engine`

## Requirements
- R1: After reset, data out is 0 while select is low. It is 1 (ready) when select is raised and nothing is being programmed.
- R2: An instruction begins at the first serial clock rise, with select high, at which data in is 1. Zeros before that are ignored. Next come the opcode (2 bits) and the address (8 bits), both MSB first. Opcode 10 is read, 01 is write (16 data bits follow), 11 erases one word and 00 is extended. For the extended opcode, address bits [7:6] choose the action: 11 sets the write-enable latch, 00 clears it, 01 writes all words (16 data bits follow) and 10 erases all words.
- R3: On a read, the serial clock rise that takes the last address bit puts a single 0 on data out. Each later rise shows the next word bit, MSB first.
- R4: While select stays high, a read goes on with the next address, wrapping from 255 to 0. No extra bit is inserted between words.
- R5: Reads return stored data whatever the state of the write-enable latch.
- R6: Reset clears the write-enable latch. The enable instruction sets it and the disable instruction clears it. While the latch is clear, write and erase instructions leave the array unchanged and start no programming.
- R7: Programming starts only if the write-allow input is high when select falls after an armed instruction.
- R8: Programming starts only if select falls before the next serial clock rise after the last instruction bit. A select fall and a clock rise seen in the same system cycle count as the fall coming first. An extra rise cancels the instruction.
- R9: Programming lasts PROG_CYCLES system clocks. While it runs, data out is 0 whenever select is high, and all bus activity is ignored. After it ends, data out shows 1 while select is high, and a new instruction may follow without dropping select.
- R10: Erase sets the addressed word to all ones. Write-all sets every word to the given data, and erase-all sets every word to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| wr_allow | input | 1 | External write permission, must be high for programming |
| sdo | output | 1 | Serial data out: read data or busy/ready level |

## Verification
Two events can fall in the same sampled cycle. One is the select fall that arms programming, which can meet a serial clock rise. The bench drives both edges in one system cycle and then reads the word back: the new value shows that the fall was taken first. The other is the end of programming while select is held high and bits are being clocked. The bench sends a partial instruction during the busy period and holds select until the level on data out turns high. It then issues a complete read without dropping select. Correct data shows that the early bits were ignored and that the engine was ready again.

// File: rtl/uwire_eeprom_engine.sv
module uwire_eeprom_engine #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  input  logic wr_allow,
  output logic sdo
);
  localparam int DEPTH = 1 << AW;
  localparam int NW    = $clog2(DW) + 1;
  localparam int CW    = $clog2(PROG_CYCLES + 1);

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADR, S_DAT, S_RD, S_ARM, S_IGN, S_BUSY
  } st_t;

  st_t            st;
  logic           sclk_q;
  logic [NW-1:0]  cnt;
  logic [1:0]     op;
  logic [AW-1:0]  adr;
  logic [DW-1:0]  sh;
  logic           all_q;
  logic           wel;
  logic           rd_bit;
  logic [CW-1:0]  pcnt;
  logic [DW-1:0]  mem [DEPTH];

  wire           rise      = sel && sclk && !sclk_q;
  wire [AW-1:0]  a_nx      = {adr[AW-2:0], sdi};
  wire [1:0]     ext       = a_nx[AW-1 -: 2];
  wire           busy_w    = (st == S_BUSY);
  wire           rd_w      = (st == S_RD);
  wire           prog_done = busy_w && (pcnt == '0);

  assign sdo = sel && (rd_w ? rd_bit : !busy_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sclk_q <= 1'b0;
      cnt    <= '0;
      op     <= '0;
      adr    <= '0;
      sh     <= '0;
      all_q  <= 1'b0;
      wel    <= 1'b0;
      rd_bit <= 1'b0;
      pcnt   <= '0;
    end else begin
      sclk_q <= sclk;
      case (st)
        S_IDLE:
          if (rise && sdi) begin
            st  <= S_OPC;
            cnt <= '0;
          end
        S_OPC:
          if (!sel) st <= S_IDLE;
          else if (rise) begin
            op <= {op[0], sdi};
            if (cnt == NW'(1)) begin
              st  <= S_ADR;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
        S_ADR:
          if (!sel) st <= S_IDLE;
          else if (rise) begin
            adr <= a_nx;
            cnt <= cnt + 1'b1;
            if (cnt == NW'(AW - 1)) begin
              cnt   <= '0;
              all_q <= 1'b0;
              case (op)
                OP_READ: begin
                  st     <= S_RD;
                  sh     <= mem[a_nx];
                  rd_bit <= 1'b0;
                end
                OP_WRITE: st <= S_DAT;
                OP_ERASE: begin
                  st <= S_ARM;
                  sh <= '1;
                end
                OP_EXT:
                  case (ext)
                    2'b11: begin wel <= 1'b1; st <= S_IGN; end
                    2'b00: begin wel <= 1'b0; st <= S_IGN; end
                    2'b01: begin all_q <= 1'b1; st <= S_DAT; end
                    2'b10: begin all_q <= 1'b1; sh <= '1; st <= S_ARM; end
                  endcase
              endcase
            end
          end
        S_DAT:
          if (!sel) st <= S_IDLE;
          else if (rise) begin
            sh <= {sh[DW-2:0], sdi};
            if (cnt == NW'(DW - 1)) begin
              cnt <= '0;
              st  <= S_ARM;
            end else cnt <= cnt + 1'b1;
          end
        S_RD:
          if (!sel) st <= S_IDLE;
          else if (rise) begin
            rd_bit <= sh[DW-1];
            if (cnt == NW'(DW - 1)) begin
              cnt <= '0;
              adr <= adr + 1'b1;
              sh  <= mem[adr + 1'b1];
            end else begin
              cnt <= cnt + 1'b1;
              sh  <= {sh[DW-2:0], 1'b0};
            end
          end
        S_ARM:
          if (!sel) begin
            if (wel && wr_allow) begin
              st   <= S_BUSY;
              pcnt <= CW'(PROG_CYCLES - 1);
            end else st <= S_IDLE;
          end else if (rise) st <= S_IGN;
        S_IGN:
          if (!sel) st <= S_IDLE;
        S_BUSY:
          if (pcnt == '0) st <= S_IDLE;
          else pcnt <= pcnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (prog_done) begin
      if (all_q) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= sh;
      end else begin
        mem[adr] <= sh;
      end
    end
  end
endmodule

module uwire_eeprom_chk #(
  parameter int PROG_CYCLES = 40
) (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic sclk,
  input logic wr_allow,
  input logic sdo,
  input logic busy,
  input logic rd,
  input logic wel
);
  int len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len <= 0;
    else if (busy) len <= len + 1;
    else len <= 0;
  end

  // R9
  busy_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel) |-> !sdo);

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len == PROG_CYCLES));

  // R8
  busy_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(sel));

  // R7
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wel) && $past(wr_allow)));

  // R6
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(sel));

  // R3
  rd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && $past(rd) && !$stable(sdo)) |-> ($past(sclk) && $past(sel)));
endmodule

bind uwire_eeprom_engine uwire_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel      (sel),
  .sclk     (sclk),
  .wr_allow (wr_allow),
  .sdo      (sdo),
  .busy     (busy_w),
  .rd       (rd_w),
  .wel      (wel)
);

// File: tb/test_uwire_eeprom_engine.sv
module test_uwire_eeprom_engine;
  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 60;

  localparam logic [23:0] VEC [6] = '{
    {8'h00, 16'hA5C3}, {8'h01, 16'h0000}, {8'h7F, 16'hFFFF},
    {8'h80, 16'h1234}, {8'hFE, 16'h8001}, {8'h3C, 16'h5A5A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic wr_allow = 1'b1;
  logic sdo;

  int   total = 0;
  int   fails = 0;
  bit   done = 1'b0;
  int   nwait;
  logic rd_dummy;
  logic [15:0] rdbuf [4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  uwire_eeprom_engine #(.PROG_CYCLES(PROG)) i_uwire_eeprom_engine (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk),
    .sdi(sdi), .wr_allow(wr_allow), .sdo(sdo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic v);
    @(negedge clk); sdi = v; sclk = 1'b0;
    @(negedge clk);
    @(negedge clk); sclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic select();
    @(negedge clk); sel = 1'b1; sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic deselect();
    @(negedge clk); sel = 1'b0; sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [7:0] a);
    sbit(1'b1); sbit(op[1]); sbit(op[0]);
    for (int i = 7; i >= 0; i--) sbit(a[i]);
  endtask

  task automatic send_word(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) sbit(d[i]);
  endtask

  task automatic wait_ready(output int n);
    select();
    n = 0;
    while (sdo !== 1'b1 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    deselect();
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    select(); send_cmd(2'b01, a); send_word(d); deselect();
    wait_ready(nwait);
  endtask

  task automatic simple(input logic [1:0] op, input logic [7:0] a);
    select(); send_cmd(op, a); deselect();
  endtask

  task automatic grab(input int n);
    for (int w = 0; w < n; w++)
      for (int b = 15; b >= 0; b--) begin
        sbit(1'b0);
        rdbuf[w][b] = sdo;
      end
  endtask

  task automatic read_seq(input logic [7:0] a, input int n, input int lead);
    select();
    for (int i = 0; i < lead; i++) sbit(1'b0);
    send_cmd(2'b10, a);
    rd_dummy = sdo;
    grab(n);
    deselect();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 sdo low in reset", 32'(sdo), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 sdo low unselected", 32'(sdo), 32'd0);
    select();
    chk("R1 ready after reset", 32'(sdo), 32'd1);
    deselect();

    // R6: reset clears the write-enable latch
    simple(2'b00, 8'hC0);
    do_write(8'h10, 16'h1111);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    do_write(8'h10, 16'h2222);
    chk("R6 no busy after reset", 32'(nwait), 32'd0);
    read_seq(8'h10, 1, 0);
    chk("R6 write refused after reset", 32'(rdbuf[0]), 32'h1111);

    // vector table: write then read back each entry
    simple(2'b00, 8'hC0);
    for (int v = 0; v < 6; v++) begin
      do_write(VEC[v][23:16], VEC[v][15:0]);
      chk("R9 busy seen after write", 32'(nwait > 0), 32'd1);
      read_seq(VEC[v][23:16], 1, 0);
      chk("R3 dummy zero", 32'(rd_dummy), 32'd0);
      chk("R3 read data", 32'(rdbuf[0]), 32'(VEC[v][15:0]));
    end

    // R4: continuous read with wrap
    do_write(8'hFF, 16'hC00F);
    read_seq(8'hFE, 4, 0);
    chk("R4 word0", 32'(rdbuf[0]), 32'h8001);
    chk("R4 word1", 32'(rdbuf[1]), 32'hC00F);
    chk("R4 wrap word2", 32'(rdbuf[2]), 32'hA5C3);
    chk("R4 word3", 32'(rdbuf[3]), 32'h0000);

    // R2: leading zeros before start bit
    read_seq(8'h3C, 1, 3);
    chk("R2 leading zeros ignored", 32'(rdbuf[0]), 32'h5A5A);

    // R6 / R5: disable then write; read still works
    simple(2'b00, 8'h00);
    do_write(8'h3C, 16'h1234);
    chk("R6 no busy when disabled", 32'(nwait), 32'd0);
    read_seq(8'h3C, 1, 0);
    chk("R5 read with latch clear", 32'(rdbuf[0]), 32'h5A5A);
    simple(2'b00, 8'hC0);

    // R7: write-allow low
    wr_allow = 1'b0;
    do_write(8'h3C, 16'h0F0F);
    wr_allow = 1'b1;
    chk("R7 no busy without allow", 32'(nwait), 32'd0);
    read_seq(8'h3C, 1, 0);
    chk("R7 word unchanged", 32'(rdbuf[0]), 32'h5A5A);

    // R8: extra clock cancels
    select(); send_cmd(2'b01, 8'h3C); send_word(16'h7777); sbit(1'b0); deselect();
    wait_ready(nwait);
    chk("R8 extra rise no busy", 32'(nwait), 32'd0);
    read_seq(8'h3C, 1, 0);
    chk("R8 extra rise cancels", 32'(rdbuf[0]), 32'h5A5A);

    // R8: select fall and clock rise in the same cycle
    select(); send_cmd(2'b01, 8'h3C); send_word(16'h2468);
    @(negedge clk); sclk = 1'b0;
    @(negedge clk); sel = 1'b0; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    wait_ready(nwait);
    read_seq(8'h3C, 1, 0);
    chk("R8 coincident fall wins", 32'(rdbuf[0]), 32'h2468);

    // R9: bits during busy are ignored; ready without dropping select
    select(); send_cmd(2'b01, 8'h50); send_word(16'hBEEF); deselect();
    select();
    chk("R9 busy level", 32'(sdo), 32'd0);
    sbit(1'b1); sbit(1'b1); sbit(1'b0);
    nwait = 0;
    while (sdo !== 1'b1 && nwait < 1000) begin
      @(negedge clk);
      nwait++;
    end
    chk("R9 ready level", 32'(sdo), 32'd1);
    send_cmd(2'b10, 8'h50);
    chk("R9 dummy after ready", 32'(sdo), 32'd0);
    grab(1);
    deselect();
    chk("R9 read after busy", 32'(rdbuf[0]), 32'hBEEF);

    // R10: erase, write-all, erase-all
    simple(2'b11, 8'h50);
    wait_ready(nwait);
    read_seq(8'h50, 1, 0);
    chk("R10 erase word", 32'(rdbuf[0]), 32'hFFFF);
    select(); send_cmd(2'b00, 8'h40); send_word(16'h6C93); deselect();
    wait_ready(nwait);
    read_seq(8'hFE, 4, 0);
    chk("R10 write-all a", 32'(rdbuf[0]), 32'h6C93);
    chk("R10 write-all b", 32'(rdbuf[2]), 32'h6C93);
    read_seq(8'h3C, 1, 0);
    chk("R10 write-all c", 32'(rdbuf[0]), 32'h6C93);
    simple(2'b00, 8'h80);
    wait_ready(nwait);
    read_seq(8'h7E, 2, 0);
    chk("R10 erase-all a", 32'(rdbuf[0]), 32'hFFFF);
    chk("R10 erase-all b", 32'(rdbuf[1]), 32'hFFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule